// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between a processor's memory stage and a data bus that carries byte write strobes. For a store it copies the byte, halfword or word of register data into every lane where the bus could want it, and raises strobe bits only for the bytes the access covers. As a result a sub-word store completes as one write and needs no earlier read. For a load it takes the word returned by the bus, picks out the addressed byte or halfword, and widens it to 32 bits by sign or by zero, according to the access code.

The access width and signedness come from a 3-bit access code in the base integer encoding: bits [1:0] give the width (00 byte, 01 halfword, 10 word, 11 unsupported), and bit 2 set means zero-extend, which applies to loads only. The block does not split accesses that are not naturally aligned. It flags them instead and blocks every strobe. All results are registered and appear one clock after the request. Bus handshaking, address generation and the register file are handled outside the block.

Top module: `lsa_aligner`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_valid`, `out_wstrb`, `out_wdata`, `out_rdata` and `out_misalign` are all zero.
- R2: Every output reflects the request presented at the previous rising edge; `out_valid` equals the `req_valid` of one cycle earlier.
- R3: A byte store (code bits [1:0]=00) gives strobe 0001 shifted left by `req_addr[1:0]` and places `req_wdata[7:0]` in all four byte lanes.
- R4: A halfword store (01) with `req_addr[0]`=0 gives strobe 0011 when `req_addr[1]`=0 and 1100 when it is 1, and places `req_wdata[15:0]` in both halves. Every nonzero strobe has one, two or four bits set.
- R5: A word store (10) at `req_addr[1:0]`=00 gives strobe 1111 and passes `req_wdata` through unchanged.
- R6: A signed load (code 000 or 001) returns the byte at bit offset 8*`req_addr[1:0]`, or the halfword at bit offset 16*`req_addr[1]`, with its top bit copied into all upper bits.
- R7: An unsigned load (code 100 or 101) returns the same byte or halfword with zeros in all upper bits.
- R8: A word load (code 010) at address offset 00 returns `bus_rdata` unchanged.
- R9: A halfword access with `req_addr[0]`=1, a word access with `req_addr[1:0]`≠00, or any code with bits [1:0]=11 sets `out_misalign`. In that case `out_wstrb`, `out_wdata` and `out_rdata` are zero.
- R10: A load never raises a strobe and leaves `out_wdata` zero, and a store leaves `out_rdata` zero. In a cycle after `req_valid` was low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_funct3 | input | 3 | Access code: [1:0] width, [2] zero-extend |
| req_addr | input | 2 | Low address bits selecting the byte lane |
| req_wdata | input | 32 | Register data to store |
| bus_rdata | input | 32 | Word returned by the bus for a load |
| out_valid | output | 1 | Registered results are valid |
| out_wstrb | output | 4 | Byte write strobe |
| out_wdata | output | 32 | Lane-replicated store data |
| out_rdata | output | 32 | Extended load result |
| out_misalign | output | 1 | Access not naturally aligned or width unsupported |

## Verification
Every result becomes due at the first rising edge after the edge that captured its request. There are no longer paths. The driver applies each request, idle cycles included, at a falling edge and queues the expected outputs, which it computes from the lane and extension rules alone. The monitor takes one entry from the queue 2 ns after each following rising edge, so each check falls inside the single cycle in which that result is valid. The reset values are checked separately before the queue comes into use.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int XLEN = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_BAD  = 2'b11
  } acc_size_e;
endpackage

// File: rtl/lsa_decode.sv
module lsa_decode
  import lsa_pkg::*;
#(
  parameter int AW = 2
) (
  input  logic [2:0]    funct3,
  input  logic [AW-1:0] addr,
  output acc_size_e     size,
  output logic          zext,
  output logic          misalign
);
  assign size = acc_size_e'(funct3[1:0]);
  assign zext = funct3[2];

  // natural alignment: the offset must be a multiple of the access width
  always_comb begin
    unique case (size)
      SZ_BYTE: misalign = 1'b0;
      SZ_HALF: misalign = addr[0];
      SZ_WORD: misalign = (addr[1:0] != 2'b00);
      default: misalign = 1'b1;
    endcase
  end
endmodule

// File: rtl/lsa_store_lanes.sv
module lsa_store_lanes
  import lsa_pkg::*;
#(
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int AW = $clog2(NB)
) (
  input  acc_size_e       size,
  input  logic [AW-1:0]   addr,
  input  logic [XLEN-1:0] wdata,
  output logic [DW-1:0]   lanes,
  output logic [NB-1:0]   strb
);
  logic [DW-1:0] rep_b, rep_h, rep_w;

  // copy the source into every lane group it may land in
  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign rep_b[8*g +: 8] = wdata[7:0];
  end
  for (genvar g = 0; g < NB/2; g++) begin : g_half
    assign rep_h[16*g +: 16] = wdata[15:0];
  end
  for (genvar g = 0; g < NB/4; g++) begin : g_word
    assign rep_w[32*g +: 32] = wdata;
  end

  logic [AW-1:0] half_base, word_base;
  assign half_base = addr & ~AW'(1);
  assign word_base = addr & ~AW'(3);

  always_comb begin
    unique case (size)
      SZ_BYTE: begin strb = NB'(1)  << addr;      lanes = rep_b; end
      SZ_HALF: begin strb = NB'(3)  << half_base; lanes = rep_h; end
      SZ_WORD: begin strb = NB'(15) << word_base; lanes = rep_w; end
      default: begin strb = '0;                   lanes = '0;    end
    endcase
  end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
  import lsa_pkg::*;
#(
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int AW = $clog2(NB)
) (
  input  logic [DW-1:0]   bus_word,
  input  logic [AW-1:0]   addr,
  input  acc_size_e       size,
  input  logic            zext,
  output logic [XLEN-1:0] result
);
  logic [AW+2:0] sh_b, sh_h, sh_w;
  logic [7:0]    pick_b;
  logic [15:0]   pick_h;
  logic [31:0]   pick_w;
  logic          fill_b, fill_h;

  assign sh_b = {addr, 3'b000};
  assign sh_h = {addr & ~AW'(1), 3'b000};
  assign sh_w = {addr & ~AW'(3), 3'b000};

  assign pick_b = 8'(bus_word >> sh_b);
  assign pick_h = 16'(bus_word >> sh_h);
  assign pick_w = 32'(bus_word >> sh_w);

  // extension bit: top bit for signed codes, zero otherwise
  assign fill_b = ~zext & pick_b[7];
  assign fill_h = ~zext & pick_h[15];

  always_comb begin
    unique case (size)
      SZ_BYTE: result = {{(XLEN-8){fill_b}}, pick_b};
      SZ_HALF: result = {{(XLEN-16){fill_h}}, pick_h};
      SZ_WORD: result = pick_w;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/lsa_aligner.sv
module lsa_aligner
  import lsa_pkg::*;
#(
  parameter int DW = 32,
  localparam int NB = DW / 8,
  localparam int AW = $clog2(NB)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_store,
  input  logic [2:0]      req_funct3,
  input  logic [AW-1:0]   req_addr,
  input  logic [XLEN-1:0] req_wdata,
  input  logic [DW-1:0]   bus_rdata,
  output logic            out_valid,
  output logic [NB-1:0]   out_wstrb,
  output logic [DW-1:0]   out_wdata,
  output logic [XLEN-1:0] out_rdata,
  output logic            out_misalign
);
  acc_size_e       size;
  logic            zext, mis;
  logic [DW-1:0]   st_lanes;
  logic [NB-1:0]   st_strb;
  logic [XLEN-1:0] ld_val;

  lsa_decode #(.AW(AW)) i_decode (
    .funct3(req_funct3), .addr(req_addr),
    .size(size), .zext(zext), .misalign(mis)
  );

  lsa_store_lanes #(.DW(DW)) i_store (
    .size(size), .addr(req_addr), .wdata(req_wdata),
    .lanes(st_lanes), .strb(st_strb)
  );

  lsa_load_extract #(.DW(DW)) i_load (
    .bus_word(bus_rdata), .addr(req_addr), .size(size),
    .zext(zext), .result(ld_val)
  );

  logic do_st, do_ld;
  assign do_st = req_valid & req_store & ~mis;
  assign do_ld = req_valid & ~req_store & ~mis;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_wstrb    <= '0;
      out_wdata    <= '0;
      out_rdata    <= '0;
      out_misalign <= 1'b0;
    end else begin
      out_valid    <= req_valid;
      out_misalign <= req_valid & mis;
      out_wstrb    <= do_st ? st_strb  : '0;
      out_wdata    <= do_st ? st_lanes : '0;
      out_rdata    <= do_ld ? ld_val   : '0;
    end
  end

  // ---------------- assertions ----------------
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(req_valid)));

  p_misalign_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    out_misalign |-> (out_wstrb == '0 && out_rdata == '0 && out_wdata == '0));

  p_strobe_shape_r4: assert property (@(posedge clk) disable iff (rst)
    (out_wstrb != '0) |->
      ($countones(out_wstrb) == 1 || $countones(out_wstrb) == 2 ||
       $countones(out_wstrb) == 4));

  p_load_no_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid && !req_store)) |-> (out_wstrb == '0));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_wstrb == '0 && !out_misalign && out_rdata == '0));
endmodule

// File: tb/test_lsa_aligner.sv
`timescale 1ns/1ps
module test_lsa_aligner;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_store = 1'b0;
  logic [2:0]  req_funct3 = '0;
  logic [1:0]  req_addr = '0;
  logic [31:0] req_wdata = '0, bus_rdata = '0;
  logic        out_valid, out_misalign;
  logic [3:0]  out_wstrb;
  logic [31:0] out_wdata, out_rdata;

  always #4 clk = ~clk;

  lsa_aligner i_lsa_aligner (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .req_funct3(req_funct3), .req_addr(req_addr), .req_wdata(req_wdata),
    .bus_rdata(bus_rdata), .out_valid(out_valid), .out_wstrb(out_wstrb),
    .out_wdata(out_wdata), .out_rdata(out_rdata), .out_misalign(out_misalign)
  );

  typedef struct {
    string       tag;
    logic        vld;
    logic [3:0]  strb;
    logic [31:0] wd;
    logic [31:0] rd;
    logic        mis;
  } exp_t;

  exp_t q[$];
  int   total = 0, bad = 0;
  bit   mon_on = 1'b0, finished = 1'b0;

  task automatic check32(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // reference model built from the requirement text
  function automatic exp_t model(string tag, logic v, logic st, logic [2:0] f3,
                                 logic [1:0] a, logic [31:0] wd, logic [31:0] rd);
    exp_t e;
    logic [7:0]  b;
    logic [15:0] h;
    e.tag = tag; e.vld = v; e.strb = 4'b0; e.wd = '0; e.rd = '0; e.mis = 1'b0;
    if (!v) return e;
    case (f3[1:0])
      2'b00: ;
      2'b01: e.mis = a[0];
      2'b10: e.mis = (a != 2'b00);
      default: e.mis = 1'b1;
    endcase
    if (e.mis) return e;
    if (st) begin
      case (f3[1:0])
        2'b00: begin
          e.wd = {wd[7:0], wd[7:0], wd[7:0], wd[7:0]};
          case (a) 2'd0: e.strb = 4'b0001; 2'd1: e.strb = 4'b0010;
                   2'd2: e.strb = 4'b0100; default: e.strb = 4'b1000; endcase
        end
        2'b01: begin
          e.wd = {wd[15:0], wd[15:0]};
          e.strb = a[1] ? 4'b1100 : 4'b0011;
        end
        default: begin e.wd = wd; e.strb = 4'b1111; end
      endcase
    end else begin
      case (f3[1:0])
        2'b00: begin
          b = rd[8*a +: 8];
          e.rd = f3[2] ? {24'h0, b} : {{24{b[7]}}, b};
        end
        2'b01: begin
          h = a[1] ? rd[31:16] : rd[15:0];
          e.rd = f3[2] ? {16'h0, h} : {{16{h[15]}}, h};
        end
        default: e.rd = rd;
      endcase
    end
    return e;
  endfunction

  task automatic drive(string tag, logic v, logic st, logic [2:0] f3,
                       logic [1:0] a, logic [31:0] wd, logic [31:0] rd);
    @(negedge clk);
    req_valid = v; req_store = st; req_funct3 = f3;
    req_addr = a; req_wdata = wd; bus_rdata = rd;
    q.push_back(model(tag, v, st, f3, a, wd, rd));
  endtask

  // monitor: results are due one rising edge after capture
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (mon_on && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check32(e.tag, "valid",    {31'h0, out_valid},    {31'h0, e.vld});
        check32(e.tag, "strobe",   {28'h0, out_wstrb},    {28'h0, e.strb});
        check32(e.tag, "wdata",    out_wdata,             e.wd);
        check32(e.tag, "rdata",    out_rdata,             e.rd);
        check32(e.tag, "misalign", {31'h0, out_misalign}, {31'h0, e.mis});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    // R1: reset state, stimulus present but reset held
    req_valid = 1'b1; req_store = 1'b1; req_funct3 = 3'b010; req_wdata = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #2;
    check32("R1", "valid in reset",  {31'h0, out_valid}, 32'h0);
    check32("R1", "strobe in reset", {28'h0, out_wstrb}, 32'h0);
    check32("R1", "wdata in reset",  out_wdata, 32'h0);
    check32("R1", "misalign in reset", {31'h0, out_misalign}, 32'h0);
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b0;
    @(posedge clk); #2;
    check32("R1", "rdata after reset", out_rdata, 32'h0);
    check32("R1", "valid after reset", {31'h0, out_valid}, 32'h0);
    mon_on = 1'b1;

    // R3: byte stores at every lane
    for (int a = 0; a < 4; a++) drive("R3", 1, 1, 3'b000, 2'(a), 32'h1234_56A7, 32'h0);
    // R4: halfword stores, both halves
    drive("R4", 1, 1, 3'b001, 2'd0, 32'hDEAD_BEEF, 32'h0);
    drive("R4", 1, 1, 3'b001, 2'd2, 32'h0000_8001, 32'h0);
    // R5: word store
    drive("R5", 1, 1, 3'b010, 2'd0, 32'hCAFE_F00D, 32'h0);
    // R2: gap cycle then back-to-back
    drive("R2", 0, 1, 3'b010, 2'd0, 32'h1111_1111, 32'h0);
    // R6: signed byte loads, negative and positive lanes
    for (int a = 0; a < 4; a++) drive("R6", 1, 0, 3'b000, 2'(a), 32'h0, 32'h7F80_11F0);
    drive("R6", 1, 0, 3'b001, 2'd0, 32'h0, 32'h1234_9ABC);
    drive("R6", 1, 0, 3'b001, 2'd2, 32'h0, 32'h8765_4321);
    drive("R6", 1, 0, 3'b001, 2'd2, 32'h0, 32'h7FFF_FFFF);
    // R7: unsigned loads
    for (int a = 0; a < 4; a++) drive("R7", 1, 0, 3'b100, 2'(a), 32'h0, 32'h80C3_FE01);
    drive("R7", 1, 0, 3'b101, 2'd0, 32'h0, 32'h0000_FFFF);
    drive("R7", 1, 0, 3'b101, 2'd2, 32'h0, 32'hA5A5_0000);
    // R8: word load
    drive("R8", 1, 0, 3'b010, 2'd0, 32'h0, 32'hF00D_8BAD);
    // R9: misaligned and unsupported codes
    drive("R9", 1, 1, 3'b001, 2'd1, 32'hFFFF_FFFF, 32'h0);
    drive("R9", 1, 1, 3'b001, 2'd3, 32'hFFFF_FFFF, 32'h0);
    drive("R9", 1, 1, 3'b010, 2'd2, 32'hFFFF_FFFF, 32'h0);
    drive("R9", 1, 0, 3'b101, 2'd3, 32'h0, 32'hFFFF_FFFF);
    drive("R9", 1, 0, 3'b010, 2'd1, 32'h0, 32'hFFFF_FFFF);
    drive("R9", 1, 1, 3'b011, 2'd0, 32'hFFFF_FFFF, 32'h0);
    drive("R9", 1, 0, 3'b111, 2'd0, 32'h0, 32'hFFFF_FFFF);
    // R10: load with store data present, store with bus data present, idle
    drive("R10", 1, 0, 3'b000, 2'd1, 32'hFFFF_FFFF, 32'h0000_FF00);
    drive("R10", 1, 1, 3'b000, 2'd1, 32'h0000_0055, 32'hFFFF_FFFF);
    drive("R10", 0, 0, 3'b010, 2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    // R2: byte store straight after misaligned access
    drive("R2", 1, 1, 3'b001, 2'd1, 32'h0, 32'h0);
    drive("R2", 1, 1, 3'b000, 2'd2, 32'h0000_003C, 32'h0);
    drive("R10", 0, 0, 3'b000, 2'd0, 32'h0, 32'h0);

    repeat (3) @(posedge clk);
    #3;
    report();
  end
endmodule